// File: doc/BRIEF.md
# Oscillation Settling Wake Timer

This block holds the system back after a wake from the deepest low-power state until the oscillator has had time to settle. Software picks one of eight settling lengths with a 3-bit select field in a byte-wide control register. When a wake request arrives, a prescaler divides the peripheral clock by the selected ratio, and a counter counts a fixed number of prescaled ticks. When the count is complete, the `settled` output rises and releases the rest of the system.

The divide ratios are 1, 64, 128, 256, 512, 1024, 4096 and 16384, and the tick count defaults to 255. The control register responds to four reset kinds in two ways. Power-on reset and entry to deep standby clear it. A manual reset and software standby leave it unchanged. Register accesses that are not byte-wide have no effect.

Top module: `osc_settle_timer`

## Requirements
- R1: The control register holds the select field in bits 2:0, and bits 7:3 always read as 0. A byte read (`reg_size` = 2'b00) returns the register. A read of any other size returns 0x00.
- R2: The select code picks the divide ratio: 0→1, 1→64, 2→128, 3→256, 4→512, 5→1024, 6→4096, 7→16384.
- R3: `settled` rises exactly SETTLE_TICKS × ratio clock edges after the edge on which `wake_req` is sampled high. SETTLE_TICKS defaults to 255.
- R4: A power-on reset clears the register to 0x00 and drives `settled` low.
- R5: Deep standby entry clears the register to 0x00 and drives `settled` low.
- R6: A manual reset keeps the register value, drives `settled` low and stops any count in progress.
- R7: Software standby entry keeps the register value and drives `settled` low.
- R8: A write whose size is not byte-wide (`reg_size` ≠ 2'b00) leaves the register unchanged.
- R9: The select field is captured on the wake edge. A write made while a count is running does change the register, but it does not change the delay of that count.
- R10: Once `settled` is high, it stays high until a standby entry or a reset. A new wake request restarts the full delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_por | input | 1 | Power-on reset, synchronous, active high |
| rst_manual | input | 1 | Manual reset, synchronous, active high |
| dstby_enter | input | 1 | Deep standby entry pulse |
| sstby_enter | input | 1 | Software standby entry pulse |
| wake_req | input | 1 | Wake request; starts the settling count |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_size | input | 2 | Access size: 00 byte, 01 half, 10 word |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| settled | output | 1 | High once the settling delay has elapsed |

## Verification
The delay to `settled` is measured to the exact clock edge for every select code on a short-tick instance. This exposes any wrong table entry or off-by-one in the prescaler wrap or the tick count. Codes 0 and 1 are also timed with the default 255 ticks, so that the real delay length is confirmed. Each reset kind is applied separately over a nonzero register value, which shows which kinds clear the register and which keep it. Writes during a running count and writes that are not byte-wide show that the delay and the register respond only to the correct stimulus.

// File: rtl/osw_pkg.sv
package osw_pkg;

    localparam int SEL_W = 3;
    localparam int REG_W = 8;
    localparam int PRE_W = 14;

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [PRE_W-1:0] wrap_t;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'b00,
        ACC_HALF = 2'b01,
        ACC_WORD = 2'b10,
        ACC_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_COUNT = 2'b01,
        ST_DONE  = 2'b10
    } tmr_state_e;

    typedef struct packed {
        logic             wr;
        logic             rd;
        acc_size_e        size;
        logic [REG_W-1:0] wdata;
    } reg_req_t;

    // Terminal prescaler value (ratio - 1) for each select code.
    function automatic wrap_t wrap_of(sel_t code);
        wrap_t one = wrap_t'(1);
        case (code)
            3'd0:    return '0;
            3'd1:    return (one << 6)  - one;
            3'd2:    return (one << 7)  - one;
            3'd3:    return (one << 8)  - one;
            3'd4:    return (one << 9)  - one;
            3'd5:    return (one << 10) - one;
            3'd6:    return (one << 12) - one;
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/osw_ctrl_reg.sv
module osw_ctrl_reg
    import osw_pkg::*;
(
    input  logic             clk,
    input  logic             clr,
    input  reg_req_t         req,
    output sel_t             sel_q,
    output logic [REG_W-1:0] rdata
);
    logic byte_acc;
    assign byte_acc = (req.size == ACC_BYTE);

    always_ff @(posedge clk) begin
        if (clr)
            sel_q <= '0;
        else if (req.wr && byte_acc)
            sel_q <= req.wdata[SEL_W-1:0];
    end

    always_comb begin
        rdata = '0;
        if (req.rd && byte_acc)
            rdata[SEL_W-1:0] = sel_q;
    end
endmodule

// File: rtl/osw_prescaler.sv
module osw_prescaler
    import osw_pkg::*;
(
    input  logic  clk,
    input  logic  clear,
    input  logic  run,
    input  wrap_t wrap,
    output logic  tick
);
    wrap_t pcnt;

    assign tick = run && (pcnt == wrap);

    always_ff @(posedge clk) begin
        if (clear)
            pcnt <= '0;
        else if (run)
            pcnt <= tick ? '0 : pcnt + wrap_t'(1);
    end
endmodule

// File: rtl/osw_sequencer.sv
module osw_sequencer
    import osw_pkg::*;
#(
    parameter int SETTLE_TICKS = 255
) (
    input  logic  clk,
    input  logic  kill,
    input  logic  wake,
    input  sel_t  sel_in,
    input  logic  tick,
    output logic  run,
    output wrap_t wrap_q,
    output logic  settled
);
    localparam int CNT_W = $clog2(SETTLE_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_TICKS - 1);

    tmr_state_e       state;
    logic [CNT_W-1:0] tcnt;

    assign run     = (state == ST_COUNT);
    assign settled = (state == ST_DONE);

    always_ff @(posedge clk) begin
        if (kill) begin
            state  <= ST_IDLE;
            tcnt   <= '0;
            wrap_q <= '0;
        end else if (wake) begin
            state  <= ST_COUNT;
            tcnt   <= '0;
            wrap_q <= wrap_of(sel_in);
        end else if (run && tick) begin
            if (tcnt == LAST)
                state <= ST_DONE;
            tcnt <= tcnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer
    import osw_pkg::*;
#(
    parameter int SETTLE_TICKS = 255
) (
    input  logic       clk,
    input  logic       rst_por,
    input  logic       rst_manual,
    input  logic       dstby_enter,
    input  logic       sstby_enter,
    input  logic       wake_req,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_size,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       settled
);
    reg_req_t req;
    sel_t     sel_q;
    wrap_t    wrap_q;
    logic     tick;
    logic     run;
    logic     reg_clr;
    logic     kill;

    assign req     = '{wr: reg_wr, rd: reg_rd, size: acc_size_e'(reg_size), wdata: reg_wdata};
    assign reg_clr = rst_por || dstby_enter;
    assign kill    = reg_clr || rst_manual || sstby_enter;

    osw_ctrl_reg u_reg (
        .clk   (clk),
        .clr   (reg_clr),
        .req   (req),
        .sel_q (sel_q),
        .rdata (reg_rdata)
    );

    osw_sequencer #(.SETTLE_TICKS(SETTLE_TICKS)) u_seq (
        .clk     (clk),
        .kill    (kill),
        .wake    (wake_req),
        .sel_in  (sel_q),
        .tick    (tick),
        .run     (run),
        .wrap_q  (wrap_q),
        .settled (settled)
    );

    osw_prescaler u_pre (
        .clk   (clk),
        .clear (kill || wake_req),
        .run   (run),
        .wrap  (wrap_q),
        .tick  (tick)
    );
endmodule

// File: rtl/osw_checker.sv
module osw_checker (
    input logic       clk,
    input logic       rst_por,
    input logic       rst_manual,
    input logic       dstby_enter,
    input logic       sstby_enter,
    input logic       wake_req,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [1:0] reg_size,
    input logic [7:0] reg_rdata,
    input logic       settled,
    input logic [2:0] sel_q,
    input logic       tick
);
    // R1: reads that are not byte-wide return zero
    a_r1_nonbyte_read_zero: assert property (@(posedge clk) disable iff (rst_por)
        (reg_rd && reg_size != 2'b00) |-> reg_rdata == 8'h00);

    // R3: settled only rises on the cycle after a prescaled tick
    a_r3_rise_after_tick: assert property (@(posedge clk) disable iff (rst_por)
        $rose(settled) |-> $past(tick));

    // R5: deep standby entry clears the register and settled
    a_r5_dstby_clears: assert property (@(posedge clk) disable iff (rst_por)
        dstby_enter |=> (sel_q == 3'd0 && !settled));

    // R6: manual reset keeps the register
    a_r6_manual_keeps: assert property (@(posedge clk) disable iff (rst_por)
        (rst_manual && !dstby_enter) |=> $stable(sel_q));

    // R7: software standby drops settled
    a_r7_standby_drops: assert property (@(posedge clk) disable iff (rst_por)
        sstby_enter |=> !settled);

    // R8: writes that are not byte-wide leave the register unchanged
    a_r8_nonbyte_write_ignored: assert property (@(posedge clk) disable iff (rst_por)
        (reg_wr && reg_size != 2'b00 && !dstby_enter) |=> $stable(sel_q));

    // R10: settled holds until standby, reset or a new wake
    a_r10_settled_holds: assert property (@(posedge clk) disable iff (rst_por)
        (settled && !wake_req && !rst_manual && !sstby_enter && !dstby_enter) |=> settled);
endmodule

bind osc_settle_timer osw_checker u_chk (
    .clk         (clk),
    .rst_por     (rst_por),
    .rst_manual  (rst_manual),
    .dstby_enter (dstby_enter),
    .sstby_enter (sstby_enter),
    .wake_req    (wake_req),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_size    (reg_size),
    .reg_rdata   (reg_rdata),
    .settled     (settled),
    .sel_q       (sel_q),
    .tick        (tick)
);

// File: tb/sim_osc_settle_timer.sv
module sim_osc_settle_timer;
    localparam int CLK_PERIOD = 10;
    localparam int FAST_TICKS = 3;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_por = 1'b1;
    logic       rst_manual = 1'b0;
    logic       dstby_enter = 1'b0;
    logic       sstby_enter = 1'b0;
    logic       wake_req = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_size = 2'b00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       settled;

    logic       b_wake = 1'b0;
    logic       b_wr = 1'b0;
    logic [7:0] b_wdata = 8'h00;
    logic [7:0] b_rdata;
    logic       b_settled;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    osc_settle_timer #(.SETTLE_TICKS(FAST_TICKS)) u0 (
        .clk(clk), .rst_por(rst_por), .rst_manual(rst_manual),
        .dstby_enter(dstby_enter), .sstby_enter(sstby_enter),
        .wake_req(wake_req), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_size(reg_size), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .settled(settled)
    );

    osc_settle_timer u1 (
        .clk(clk), .rst_por(rst_por), .rst_manual(1'b0),
        .dstby_enter(1'b0), .sstby_enter(1'b0),
        .wake_req(b_wake), .reg_wr(b_wr), .reg_rd(1'b0),
        .reg_size(2'b00), .reg_wdata(b_wdata),
        .reg_rdata(b_rdata), .settled(b_settled)
    );

    function automatic int ratio(int code);
        case (code)
            0: return 1;
            1: return 64;
            2: return 128;
            3: return 256;
            4: return 512;
            5: return 1024;
            6: return 4096;
            default: return 16384;
        endcase
    endfunction

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic wr(logic [7:0] d, logic [1:0] sz);
        reg_wr = 1'b1; reg_wdata = d; reg_size = sz;
        @(negedge clk);
        reg_wr = 1'b0; reg_size = 2'b00;
    endtask

    task automatic rd(logic [1:0] sz, output int v);
        reg_rd = 1'b1; reg_size = sz;
        #1 v = int'(reg_rdata);
        @(negedge clk);
        reg_rd = 1'b0; reg_size = 2'b00;
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    // Pulse a wake on u0 and return the edges from the wake edge until settled.
    task automatic time_wake(int limit, int mid_write, output int n);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        n = 0;
        while (!settled && n < limit) begin
            if (n == 5 && mid_write >= 0) begin
                reg_wr = 1'b1; reg_wdata = 8'(mid_write); reg_size = 2'b00;
            end
            @(negedge clk);
            reg_wr = 1'b0;
            n++;
        end
    endtask

    task automatic t_reset_state();
        int v;
        check("R4 settled low after power-on", int'(settled), 0);
        rd(2'b00, v);
        check("R4 register 0 after power-on", v, 0);
    endtask

    task automatic t_register_fields();
        int v;
        wr(8'hFD, 2'b00);
        rd(2'b00, v);
        check("R1 reserved bits read zero", v, 8'h05);
        rd(2'b10, v);
        check("R1 word read returns zero", v, 0);
        wr(8'h02, 2'b01);
        rd(2'b00, v);
        check("R8 half write ignored", v, 8'h05);
        wr(8'h03, 2'b10);
        rd(2'b00, v);
        check("R8 word write ignored", v, 8'h05);
    endtask

    task automatic t_all_codes();
        int n;
        for (int c = 0; c < 8; c++) begin
            wr(8'(c), 2'b00);
            time_wake(FAST_TICKS * ratio(c) + 10, -1, n);
            check($sformatf("R2 R3 delay code %0d", c), n, FAST_TICKS * ratio(c));
            pulse(sstby_enter);
        end
    endtask

    task automatic t_default_ticks();
        for (int c = 0; c < 2; c++) begin
            int n = 0;
            b_wr = 1'b1; b_wdata = 8'(c);
            @(negedge clk);
            b_wr = 1'b0; b_wake = 1'b1;
            @(negedge clk);
            b_wake = 1'b0;
            while (!b_settled && n < 255 * ratio(c) + 10) begin
                @(negedge clk);
                n++;
            end
            check($sformatf("R3 default 255 ticks code %0d", c), n, 255 * ratio(c));
        end
    endtask

    task automatic t_sample_at_start();
        int n, v;
        wr(8'h01, 2'b00);
        time_wake(FAST_TICKS * 64 + 10, 7, n);
        check("R9 delay uses code captured at wake", n, FAST_TICKS * 64);
        rd(2'b00, v);
        check("R9 write during count lands in register", v, 7);
    endtask

    task automatic t_hold_and_resets();
        int n, v;
        repeat (20) @(negedge clk);
        check("R10 settled holds", int'(settled), 1);
        wr(8'h00, 2'b00);
        time_wake(FAST_TICKS + 10, -1, n);
        check("R10 new wake restarts delay", n, FAST_TICKS);
        pulse(sstby_enter);
        check("R7 settled low after software standby", int'(settled), 0);
        wr(8'h06, 2'b00);
        pulse(sstby_enter);
        rd(2'b00, v);
        check("R7 software standby keeps register", v, 6);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        repeat (10) @(negedge clk);
        pulse(rst_manual);
        repeat (FAST_TICKS * 4096 + 10) @(negedge clk);
        check("R6 manual reset stops count", int'(settled), 0);
        rd(2'b00, v);
        check("R6 manual reset keeps register", v, 6);
        pulse(dstby_enter);
        rd(2'b00, v);
        check("R5 deep standby clears register", v, 0);
        wr(8'h00, 2'b00);
        time_wake(FAST_TICKS + 10, -1, n);
        pulse(dstby_enter);
        check("R5 deep standby drops settled", int'(settled), 0);
        wr(8'h04, 2'b00);
        rst_por = 1'b1;
        @(negedge clk);
        rst_por = 1'b0;
        rd(2'b00, v);
        check("R4 power-on reset clears register", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_por = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_register_fields();
        t_all_codes();
        t_default_ticks();
        t_sample_at_start();
        t_hold_and_resets();
        done = 1;
        finish_run();
    end
endmodule